// File: doc/BRIEF.md
# Parallel Additive LFSR Scrambler

This block whitens a data stream one word per clock. It keeps an M-bit Galois-form linear feedback shift register and, for every accepted N-bit word, combines each data bit with a keystream bit taken from that register. In the same clock the register jumps forward by N serial steps. The jump depends only on the register contents, never on the data, so the block is an additive (frame-synchronous) scrambler. Each accepted word gives exactly the bits that a one-bit serial scrambler with the same polynomial would produce over N clocks. Data bit 0 is the first bit of the serial stream.

The keystream and the state jump are built from one-hot response matrices that are worked out when the block is elaborated. Each output bit is then one XOR tree over a fixed subset of state bits, plus its own data bit. The word width, register width and feedback polynomial are parameters. A seed strobe loads the register with all ones. Scrambling and descrambling are the same operation, so a second instance started from the same seed restores the original data.

Data enters and leaves over valid/ready handshakes. A word transfers on a clock edge where `in_valid` and `in_ready` are both high. The result sits in a one-word output register. It stays there, unchanged, until a clock edge that sees `out_valid` and `out_ready` high together. `in_ready` is high while that register is empty or is being emptied in the same cycle. When the sink stalls, back-pressure therefore reaches the source at once, and no word is dropped.

Top module: `parallel_scrambler`

## Requirements
- R1: An accepted word is scrambled with a serial reference. The reference walks data bits from index 0 up to N-1. For each bit it emits data[b] XOR q[M-1] and then takes one Galois step on q: new[0] = q[M-1], and for k ≥ 1, new[k] = q[k-1] XOR (POLY[k] AND q[M-1]). The scrambled word appears on `out_data`, and the register afterwards holds q after N steps. POLY bit k is the coefficient of x^k; bit 0 must be 1 and x^M is implied.
- R2: The state after a word depends only on the state before it. Two different words sent from the same state leave the same keystream (out_data XOR in_data), both in that word and in the following word.
- R3: After reset, `out_valid` is 0, `out_data` is 0, `in_ready` is 1 and the register holds all ones. A first word d therefore comes out scrambled with the all-ones keystream.
- R4: `seed_load` high at a clock edge sets the register to all ones. If a word is accepted at that same edge, the word is scrambled from the all-ones state, and the register then holds the N-step advance of all ones.
- R5: At an edge with no accepted word and no seed, the register keeps its value. `out_data` also keeps its value until the next accepted word.
- R6: `in_ready` equals (NOT out_valid) OR out_ready. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R7: `out_valid` goes high on the edge that accepts a word, which is one cycle of latency. It goes low on an edge that sees `out_ready` high and accepts no new word.
- R8: Send a scrambled sequence through the block after the same seed and the original words come back.
- R9: The same behaviour holds for other parameter sets. Examples are a 32-bit word with x^16+x^5+x^4+x^3+1, and a 1-bit word with x^7+x^6+1 (POLY = 7'h41, so new[6] = q[5] XOR q[6]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Loads the register with all ones at the next edge |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | DATA_W | Word to scramble or descramble |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Sink takes the output this cycle |
| out_data | output | DATA_W | Scrambled word |

## Verification
Two things can land on one clock edge: a seed reload and an accepted word. The seed must win, and the word must use the fresh all-ones state. The bench raises `seed_load` and `in_valid` together, both in directed steps and in random runs where the register is somewhere mid-sequence. It judges the output word and the following words against a bit-serial model that reloads ones before it scrambles. A second overlap is also covered: a word accepted in the same cycle that a stalled result is released. The random sink back-pressure exercises it, and the bench checks that no word is lost or repeated.

// File: rtl/scr_pkg.sv
package scr_pkg;

  // Widest register the elaboration-time helpers support.
  localparam int SCR_MAX_W = 64;

  typedef logic [SCR_MAX_W-1:0] scr_vec_t;

  // One Galois shift of an m-bit register; taps[k] is the x^k coefficient.
  function automatic scr_vec_t galois_step(scr_vec_t q, scr_vec_t taps, int m);
    scr_vec_t nq;
    logic     fb;
    fb = q[m-1];
    nq = '0;
    for (int k = 0; k < SCR_MAX_W; k++) begin
      if (k == 0) begin
        nq[k] = fb;
      end else if (k < m) begin
        nq[k] = q[k-1] ^ (taps[k] & fb);
      end
    end
    return nq;
  endfunction

  // Apply galois_step a given number of times.
  function automatic scr_vec_t galois_advance(scr_vec_t q, scr_vec_t taps, int m, int steps);
    scr_vec_t r;
    r = q;
    for (int s = 0; s < steps; s++) begin
      r = galois_step(r, taps, m);
    end
    return r;
  endfunction

endpackage

// File: rtl/scr_state_adv.sv
// N-step jump of the register: each next-state bit is an XOR of a fixed
// subset of current-state bits, found from one-hot responses.
module scr_state_adv
  import scr_pkg::*;
#(
  parameter int unsigned             STEPS  = 8,
  parameter int unsigned             REG_W  = 16,
  parameter logic [REG_W-1:0]        TAPS   = 16'h0039
) (
  input  logic [REG_W-1:0] cur_state,
  output logic [REG_W-1:0] nxt_state
);

  localparam int MAT_BITS = REG_W * REG_W;

  // Row j (REG_W bits) = mask of cur_state bits that feed nxt_state[j].
  function automatic logic [MAT_BITS-1:0] build_adv();
    logic [MAT_BITS-1:0] mat;
    scr_vec_t            resp;
    mat = '0;
    for (int i = 0; i < int'(REG_W); i++) begin
      resp = galois_advance(scr_vec_t'(1) << i, scr_vec_t'(TAPS), int'(REG_W), int'(STEPS));
      for (int j = 0; j < int'(REG_W); j++) begin
        mat[j*int'(REG_W) + i] = resp[j];
      end
    end
    return mat;
  endfunction

  localparam logic [MAT_BITS-1:0] ADV_MAT = build_adv();

  for (genvar j = 0; j < int'(REG_W); j++) begin : g_row
    assign nxt_state[j] = ^(cur_state & ADV_MAT[j*REG_W +: REG_W]);
  end

endmodule

// File: rtl/scr_keystream.sv
// Keystream for one word: bit n is the register MSB after n serial steps,
// written as an XOR of a fixed subset of the current state.
module scr_keystream
  import scr_pkg::*;
#(
  parameter int unsigned      WORD_W = 8,
  parameter int unsigned      REG_W  = 16,
  parameter logic [REG_W-1:0] TAPS   = 16'h0039
) (
  input  logic [REG_W-1:0]  cur_state,
  output logic [WORD_W-1:0] key
);

  localparam int MAT_BITS = WORD_W * REG_W;

  function automatic logic [MAT_BITS-1:0] build_key();
    logic [MAT_BITS-1:0] mat;
    scr_vec_t            resp;
    mat = '0;
    for (int i = 0; i < int'(REG_W); i++) begin
      resp = scr_vec_t'(1) << i;
      for (int n = 0; n < int'(WORD_W); n++) begin
        mat[n*int'(REG_W) + i] = resp[int'(REG_W)-1];
        resp = galois_step(resp, scr_vec_t'(TAPS), int'(REG_W));
      end
    end
    return mat;
  endfunction

  localparam logic [MAT_BITS-1:0] KEY_MAT = build_key();

  for (genvar n = 0; n < int'(WORD_W); n++) begin : g_bit
    assign key[n] = ^(cur_state & KEY_MAT[n*REG_W +: REG_W]);
  end

endmodule

// File: rtl/scr_out_stage.sv
// One-word output register with valid/ready handshake; the data-to-output
// matrix is the identity, so each bit is its data bit XOR its key bit.
module scr_out_stage #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  input  logic [WORD_W-1:0] key,
  input  logic              sink_ready,
  output logic              space_ok,
  output logic              held_valid,
  output logic [WORD_W-1:0] held_data
);

  assign space_ok = !held_valid || sink_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_data  <= '0;
    end else if (take) begin
      held_valid <= 1'b1;
      held_data  <= word_in ^ key;
    end else if (sink_ready) begin
      held_valid <= 1'b0;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && !sink_ready) |=> (held_valid && $stable(held_data)));

  // R7
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_valid) |-> $past(take));

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && sink_ready && !take) |=> !held_valid);

endmodule

// File: rtl/parallel_scrambler.sv
module parallel_scrambler
  import scr_pkg::*;
#(
  parameter int unsigned         DATA_W = 8,
  parameter int unsigned         POLY_W = 16,
  parameter logic [POLY_W-1:0]   POLY   = 16'h0039
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam logic [POLY_W-1:0] SEED = '1;

  logic [POLY_W-1:0] state_q;
  logic [POLY_W-1:0] base_state;
  logic [POLY_W-1:0] adv_state;
  logic [DATA_W-1:0] key;
  logic              accept;

  // A seed in the same cycle as a word takes effect before the word.
  assign base_state = seed_load ? SEED : state_q;
  assign accept     = in_valid && in_ready;

  scr_state_adv #(
    .STEPS (DATA_W),
    .REG_W (POLY_W),
    .TAPS  (POLY)
  ) u_adv (
    .cur_state (base_state),
    .nxt_state (adv_state)
  );

  scr_keystream #(
    .WORD_W (DATA_W),
    .REG_W  (POLY_W),
    .TAPS   (POLY)
  ) u_key (
    .cur_state (base_state),
    .key       (key)
  );

  scr_out_stage #(
    .WORD_W (DATA_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (accept),
    .word_in    (in_data),
    .key        (key),
    .sink_ready (out_ready),
    .space_ok   (in_ready),
    .held_valid (out_valid),
    .held_data  (out_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (accept) begin
      state_q <= adv_state;
    end else if (seed_load) begin
      state_q <= SEED;
    end
  end

  // R5
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !accept) |=> $stable(state_q));

  // R4
  seed_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && !accept) |=> (state_q == SEED));

  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: tb/sim_parallel_scrambler.sv
module sim_parallel_scrambler;

  localparam int M0 = 16;
  localparam int N0 = 8;
  localparam logic [15:0] P0 = 16'h0039;
  localparam int N1 = 32;
  localparam int M2 = 7;
  localparam int N2 = 1;
  localparam logic [6:0] P2 = 7'h41;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [N0-1:0] d0 = '0;
  logic [N1-1:0] d1 = '0;
  logic [N2-1:0] d2 = '0;
  logic rdy0, rdy1, rdy2, ov0, ov1, ov2;
  logic [N0-1:0] od0;
  logic [N1-1:0] od1;
  logic [N2-1:0] od2;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  parallel_scrambler #(.DATA_W(N0), .POLY_W(M0), .POLY(P0)) u0 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .in_valid(in_valid),
    .in_ready(rdy0), .in_data(d0), .out_valid(ov0), .out_ready(out_ready),
    .out_data(od0));

  parallel_scrambler #(.DATA_W(N1), .POLY_W(M0), .POLY(P0)) u1 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .in_valid(in_valid),
    .in_ready(rdy1), .in_data(d1), .out_valid(ov1), .out_ready(1'b1),
    .out_data(od1));

  parallel_scrambler #(.DATA_W(N2), .POLY_W(M2), .POLY(P2)) u2 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .in_valid(in_valid),
    .in_ready(rdy2), .in_data(d2), .out_valid(ov2), .out_ready(1'b1),
    .out_data(od2));

  // Bench-side serial model
  logic [63:0] st0, st1, st2;
  logic        eov0, eov1, eov2;
  logic [63:0] eod0, eod1, eod2;

  function automatic logic [63:0] ser_step(logic [63:0] q, logic [63:0] taps, int m);
    logic [63:0] r;
    r = '0;
    r[0] = q[m-1];
    for (int k = 1; k < m; k++) r[k] = q[k-1] ^ (taps[k] & q[m-1]);
    return r;
  endfunction

  task automatic ser_word(input logic [63:0] taps, input int m, input int n,
                          inout logic [63:0] st, input logic [63:0] din,
                          output logic [63:0] dout);
    dout = '0;
    for (int b = 0; b < n; b++) begin
      dout[b] = din[b] ^ st[m-1];
      st = ser_step(st, taps, m);
    end
  endtask

  function automatic logic [63:0] ones(int m);
    return (64'd1 << m) - 64'd1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive just after a falling edge, check at the next one.
  task automatic cyc(input bit seed, input bit vld, input bit ordy,
                     input logic [63:0] x0, input logic [63:0] x1, input logic [63:0] x2);
    bit acc;
    bit rdy_exp;
    logic [63:0] tmp;
    seed_load = seed; in_valid = vld; out_ready = ordy;
    d0 = x0[N0-1:0]; d1 = x1[N1-1:0]; d2 = x2[N2-1:0];
    #1;
    rdy_exp = !eov0 || ordy;
    chk(rdy0 == rdy_exp, "R6 in_ready", 64'(rdy0), 64'(rdy_exp));
    acc = vld && rdy_exp;
    if (seed) begin st0 = ones(M0); st1 = ones(M0); st2 = ones(M2); end
    if (acc) begin
      ser_word(64'(P0), M0, N0, st0, x0, tmp); eod0 = tmp; eov0 = 1'b1;
    end else if (ordy) eov0 = 1'b0;
    if (vld) begin
      ser_word(64'(P0), M0, N1, st1, x1, tmp); eod1 = tmp;
      ser_word(64'(P2), M2, N2, st2, x2, tmp); eod2 = tmp;
    end
    eov1 = vld; eov2 = vld;
    @(negedge clk);
    chk(ov0 == eov0, "R7 out_valid", 64'(ov0), 64'(eov0));
    if (acc) chk(64'(od0) == eod0, "R1 out_data", 64'(od0), eod0);
    else     chk(64'(od0) == eod0, "R5 out_data held", 64'(od0), eod0);
    chk(ov1 == eov1 && 64'(od1) == eod1, "R9 32-bit word", 64'(od1), eod1);
    chk(ov2 == eov2 && 64'(od2) == eod2, "R9 7-bit poly", 64'(od2), eod2);
  endtask

  logic [63:0] ref_o, key_a, key_b, key_a2, key_b2;
  logic [63:0] tmp_st;
  logic [7:0]  plain [6];
  logic [7:0]  scram [6];

  initial begin
    void'($urandom(32'd1234));
    st0 = ones(M0); st1 = ones(M0); st2 = ones(M2);
    eov0 = 0; eov1 = 0; eov2 = 0; eod0 = 0; eod1 = 0; eod2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3 reset state
    chk(ov0 == 1'b0, "R3 out_valid", 64'(ov0), 64'd0);
    chk(od0 == '0, "R3 out_data", 64'(od0), 64'd0);
    chk(rdy0 == 1'b1, "R3 in_ready", 64'(rdy0), 64'd1);
    @(negedge clk);
    cyc(0, 1, 1, 64'h5a, 64'hdeadbeef, 64'h1);
    tmp_st = ones(M0);
    ser_word(64'(P0), M0, N0, tmp_st, 64'h5a, ref_o);
    chk(64'(od0) == ref_o, "R3 first word uses all-ones state", 64'(od0), ref_o);

    // R4 seed and word in the same cycle, from a mid-sequence state
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 64'($urandom), 64'($urandom), 64'($urandom));
    cyc(1, 1, 1, 64'h3c, 64'h0, 64'h0);
    tmp_st = ones(M0);
    ser_word(64'(P0), M0, N0, tmp_st, 64'h3c, ref_o);
    chk(64'(od0) == ref_o, "R4 seed with word", 64'(od0), ref_o);
    cyc(0, 1, 1, 64'h00, 64'h0, 64'h0);
    ser_word(64'(P0), M0, N0, tmp_st, 64'h00, ref_o);
    chk(64'(od0) == ref_o, "R4 word after seed", 64'(od0), ref_o);
    // R4 seed alone
    cyc(1, 0, 1, 64'h0, 64'h0, 64'h0);
    cyc(0, 1, 1, 64'hff, 64'h0, 64'h0);
    tmp_st = ones(M0);
    ser_word(64'(P0), M0, N0, tmp_st, 64'hff, ref_o);
    chk(64'(od0) == ref_o, "R4 seed alone", 64'(od0), ref_o);

    // R2 keystream independent of data
    cyc(1, 1, 1, 64'h00, 64'h0, 64'h0); key_a = 64'(od0) ^ 64'h00;
    cyc(0, 1, 1, 64'h00, 64'h0, 64'h0); key_a2 = 64'(od0);
    cyc(1, 1, 1, 64'ha7, 64'h0, 64'h0); key_b = 64'(od0) ^ 64'ha7;
    cyc(0, 1, 1, 64'h19, 64'h0, 64'h0); key_b2 = 64'(od0) ^ 64'h19;
    chk(key_a == key_b, "R2 same keystream word 1", key_b, key_a);
    chk(key_a2 == key_b2, "R2 same keystream word 2", key_b2, key_a2);

    // R5 idle cycles keep state and output
    cyc(0, 0, 1, 64'h0, 64'h0, 64'h0);
    cyc(0, 0, 0, 64'h0, 64'h0, 64'h0);
    cyc(0, 1, 1, 64'h77, 64'h0, 64'h0);

    // R6 stall: output holds, input blocked
    cyc(0, 1, 0, 64'h11, 64'h0, 64'h0);
    cyc(0, 1, 0, 64'h22, 64'h0, 64'h0);
    cyc(0, 1, 0, 64'h33, 64'h0, 64'h0);
    cyc(0, 1, 1, 64'h44, 64'h0, 64'h0);

    // R8 descramble round trip
    cyc(1, 0, 1, 64'h0, 64'h0, 64'h0);
    for (int i = 0; i < 6; i++) begin
      plain[i] = 8'($urandom);
      cyc(0, 1, 1, 64'(plain[i]), 64'h0, 64'h0);
      scram[i] = od0;
    end
    cyc(1, 0, 1, 64'h0, 64'h0, 64'h0);
    for (int i = 0; i < 6; i++) begin
      cyc(0, 1, 1, 64'(scram[i]), 64'h0, 64'h0);
      chk(od0 == plain[i], "R8 recovered word", 64'(od0), 64'(plain[i]));
    end

    // Random traffic with back-pressure and occasional seeds
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 40) == 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
          {$urandom, $urandom}, {$urandom, $urandom}, 64'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule